// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing control and status layer of a serial port. It sits on a byte-wide register bus with a 6-bit address, a write strobe and a read strobe. Every access completes in one clock, and read data is combinational from the current state. Serialisation, baud timing and receive storage live in neighbouring blocks. The front end reaches the receive FIFO through a level/head-byte/pop/flush port, and it passes transmit bytes to a shifter with a valid/ready handshake.

Software configures the port through two mode bytes that share one offset. An internal pointer picks which of the two is accessed. A single command byte carries three independent sub-commands: a general action, a transmitter control and a receiver control. The block keeps a one-byte transmit holding register and reports its state through ready and empty flags. Interrupt sources are collected into a status byte, gated by a mask and folded into one registered, level-sensitive interrupt line.

Top module: `sio_ctrl_regs`

## Requirements
- R1: After reset both mode bytes, the interrupt status, the mask, `irq`, `txValid` and `rxEnable` are zero, and the status byte reads 0x08 while the FIFO level and `rxErrBits` are zero.
- R2: Offset 0x00 accesses mode byte 1 when the pointer is 0 and mode byte 2 when it is 1. Every write there sets the pointer to 1. General action code 1 returns it to 0. Reads do not move it.
- R3: The status byte at 0x04 is laid out as follows. Bit0 is set when the FIFO level is nonzero. Bit1 is set when the level equals FIFO_DEPTH. Bit2 is the transmitter enable. Bit3 is set when no transmit byte is pending. Bits 7:4 are `rxErrBits[3:0]`, with bit4 the overrun flag and bit7 the break flag.
- R4: In a command byte written at 0x08, bits 1:0 control the receiver: 1 enables it, 2 disables it, and 0 or 3 leave it unchanged. General action code 2 (bits 6:4) disables the receiver and pulses `rxFlush` in the write cycle. The 2-bit field is applied after the general action.
- R5: Bits 3:2 of the command control the transmitter: 1 enables it, 2 disables it, and 0 or 3 leave it unchanged. General action code 3 disables the transmitter and drops any pending byte. The 2-bit field is applied after the general action.
- R6: A write at 0x0C latches the byte and marks it pending. `txValid` is high exactly when the transmitter is enabled and a byte is pending, and `txData` carries the latched byte. The pending mark clears on the edge where `txValid` and `txReady` are both high. A pending byte waits while the transmitter is disabled.
- R7: A read at 0x0C with a nonzero FIFO level returns `rxHeadData` and raises `rxPop` for that cycle. With the level at zero it returns 0 and `rxPop` stays low.
- R8: The interrupt status at 0x14 is laid out as follows. Bit0 is the transmitter enable. Bit1 is the FIFO-full flag when bit 6 of mode byte 1 is set, and the FIFO-non-empty flag otherwise. Bit2 is a latch that a `breakEvt` pulse sets and general action code 5 clears. Bits 7:3 are zero.
- R9: A write at 0x14 loads the mask. `irq` equals the OR of (interrupt status AND mask) as it stood one clock earlier.
- R10: Reads at 0x18 and 0x1C return the high and low bytes of the BAUD_DIV parameter. Reads at any other unlisted address return 0, and writes to any address other than 0x00, 0x08, 0x0C and 0x14 change nothing.
- R11: General action codes 0, 4, 6 and 7, and bit 7 of the command byte, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid in the cycle of the read |
| rxLevel | input | LEVEL_W | Bytes held in the receive FIFO |
| rxHeadData | input | 8 | Oldest byte in the receive FIFO |
| rxErrBits | input | 4 | Receive error flags: overrun, parity, framing, break |
| breakEvt | input | 1 | One-cycle pulse on a break-state change |
| rxPop | output | 1 | Removes the head byte from the FIFO |
| rxFlush | output | 1 | Empties the FIFO |
| rxEnable | output | 1 | Receiver enable |
| txValid | output | 1 | Transmit byte offered to the shifter |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Shifter accepts the byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps all 256 command bytes from both an all-enabled and an all-disabled starting state. This exposes a decoder that gives a general reset priority over a same-byte enable, that reacts to reserved field code 3 or to bit 7, or that moves the mode pointer on the wrong code. The status layout and the receive interrupt select are swept over every FIFO level, every error pattern, both transmitter states and both settings of the mode bit. A design with a swapped flag or a wrong full threshold would fail there. Every one of the 64 addresses is read and written to catch stray decodes. The transmit handshake is checked with a byte waiting on a disabled transmitter and with the shifter stalling, so a design that drops, loses or re-sends the byte shows up.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam logic [5:0] OFF_MODE = 6'h00;
  localparam logic [5:0] OFF_STAT = 6'h04;
  localparam logic [5:0] OFF_CMD  = 6'h08;
  localparam logic [5:0] OFF_DATA = 6'h0C;
  localparam logic [5:0] OFF_INT  = 6'h14;
  localparam logic [5:0] OFF_DIVH = 6'h18;
  localparam logic [5:0] OFF_DIVL = 6'h1C;

  // general-action codes (command bits 6:4)
  localparam logic [2:0] ACT_PTR_RST = 3'd1;
  localparam logic [2:0] ACT_RX_RST  = 3'd2;
  localparam logic [2:0] ACT_TX_RST  = 3'd3;
  localparam logic [2:0] ACT_BRK_CLR = 3'd5;

  // 2-bit direction field codes
  localparam logic [1:0] DIR_ON  = 2'd1;
  localparam logic [1:0] DIR_OFF = 2'd2;

  typedef struct packed {
    logic wrMode;
    logic wrMask;
    logic wrTx;
    logic popRx;
    logic ptrReset;
    logic rxReset;
    logic txReset;
    logic clrBreak;
    logic txOn;
    logic txOff;
    logic rxOn;
    logic rxOff;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_STAT, SEL_RXD, SEL_ISR, SEL_DIVH, SEL_DIVL
  } rdSel_t;

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
  import sio_pkg::*;
(
  input  logic [5:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busWrData,
  input  logic       rxAvail,
  output ctlStrobe_t st,
  output rdSel_t     rdSel
);

  logic [2:0] actCode;
  logic [1:0] txField;
  logic [1:0] rxField;
  logic       unusedTopBit;

  assign actCode      = busWrData[6:4];
  assign txField      = busWrData[3:2];
  assign rxField      = busWrData[1:0];
  assign unusedTopBit = busWrData[7];

  always_comb begin
    st = '0;
    if (busWrEn) begin
      case (busAddr)
        OFF_MODE: st.wrMode = 1'b1;
        OFF_DATA: st.wrTx   = 1'b1;
        OFF_INT:  st.wrMask = 1'b1;
        OFF_CMD: begin
          case (actCode)
            ACT_PTR_RST: st.ptrReset = 1'b1;
            ACT_RX_RST:  st.rxReset  = 1'b1;
            ACT_TX_RST:  st.txReset  = 1'b1;
            ACT_BRK_CLR: st.clrBreak = 1'b1;
            default:     ;
          endcase
          st.txOn  = (txField == DIR_ON);
          st.txOff = (txField == DIR_OFF);
          st.rxOn  = (rxField == DIR_ON);
          st.rxOff = (rxField == DIR_OFF);
        end
        default: ;
      endcase
    end
    if (busRdEn && busAddr == OFF_DATA) st.popRx = rxAvail;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (busRdEn) begin
      case (busAddr)
        OFF_MODE: rdSel = SEL_MODE;
        OFF_STAT: rdSel = SEL_STAT;
        OFF_DATA: rdSel = SEL_RXD;
        OFF_INT:  rdSel = SEL_ISR;
        OFF_DIVH: rdSel = SEL_DIVH;
        OFF_DIVL: rdSel = SEL_DIVL;
        default:  rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int          FIFO_DEPTH = 4,
  parameter logic [15:0] BAUD_DIV   = 16'h1234,
  localparam int         LEVEL_W    = $clog2(FIFO_DEPTH + 1),
  localparam int         MODE_CNT   = 2,
  localparam int         RXSEL_BIT  = 6
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         st,
  input  rdSel_t             rdSel,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [7:0]         rxHeadData,
  input  logic [3:0]         rxErrBits,
  input  logic               breakEvt,
  output logic               rxAvail,
  output logic               rxFlush,
  output logic               rxEnable,
  output logic               txValid,
  output logic [7:0]         txData,
  input  logic               txReady,
  output logic               irq
);

  logic [7:0] modeReg [MODE_CNT];
  logic       modePtr;
  logic [7:0] intMask;
  logic       txEn, rxEn, txPending, breakChg, irqQ;
  logic [7:0] txHold;
  logic       fifoFull, rxIntSrc;
  logic [7:0] statusVec, isrVec;

  for (genvar i = 0; i < MODE_CNT; i++) begin : g_mode
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (st.wrMode && modePtr == 1'(i)) q <= wrData;
    end
    assign modeReg[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modePtr <= 1'b0;
    else if (st.ptrReset) modePtr <= 1'b0;
    else if (st.wrMode) modePtr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intMask <= '0;
    else if (st.wrMask) intMask <= wrData;
  end

  // direction fields are applied after the general reset action
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
    end else begin
      if (st.txOn) txEn <= 1'b1;
      else if (st.txOff || st.txReset) txEn <= 1'b0;
      if (st.rxOn) rxEn <= 1'b1;
      else if (st.rxOff || st.rxReset) rxEn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPending <= 1'b0;
      txHold    <= '0;
    end else if (st.wrTx) begin
      txPending <= 1'b1;
      txHold    <= wrData;
    end else if (st.txReset || (txValid && txReady)) begin
      txPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) breakChg <= 1'b0;
    else if (breakEvt) breakChg <= 1'b1;
    else if (st.clrBreak) breakChg <= 1'b0;
  end

  assign rxAvail   = (rxLevel != '0);
  assign fifoFull  = (rxLevel == LEVEL_W'(FIFO_DEPTH));
  assign rxIntSrc  = modeReg[0][RXSEL_BIT] ? fifoFull : rxAvail;
  assign statusVec = {rxErrBits, ~txPending, txEn, fifoFull, rxAvail};
  assign isrVec    = {5'b0, breakChg, rxIntSrc, txEn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else irqQ <= |(isrVec & intMask);
  end

  always_comb begin
    case (rdSel)
      SEL_MODE: rdData = modeReg[modePtr];
      SEL_STAT: rdData = statusVec;
      SEL_RXD:  rdData = rxAvail ? rxHeadData : 8'h00;
      SEL_ISR:  rdData = isrVec;
      SEL_DIVH: rdData = BAUD_DIV[15:8];
      SEL_DIVL: rdData = BAUD_DIV[7:0];
      default:  rdData = 8'h00;
    endcase
  end

  assign txValid  = txEn && txPending;
  assign txData   = txHold;
  assign rxFlush  = st.rxReset;
  assign rxEnable = rxEn;
  assign irq      = irqQ;

  // R2
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrMode |=> modePtr);

  // R4
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxReset && !st.rxOn) |=> !rxEnable);

  // R5
  tx_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.txReset && !st.txOn) |=> (!txValid && statusVec[3]));

  // R6
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !st.wrTx) |=> statusVec[3]);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !st.wrTx && !st.txReset && !st.txOff)
      |=> (txValid && $stable(txData)));

  // R8
  brk_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakEvt |=> isrVec[2]);

endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
  import sio_pkg::*;
#(
  parameter int          FIFO_DEPTH = 4,
  parameter logic [15:0] BAUD_DIV   = 16'h1234,
  localparam int         LEVEL_W    = $clog2(FIFO_DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [5:0]         busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [7:0]         busWrData,
  output logic [7:0]         busRdData,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [7:0]         rxHeadData,
  input  logic [3:0]         rxErrBits,
  input  logic               breakEvt,
  output logic               rxPop,
  output logic               rxFlush,
  output logic               rxEnable,
  output logic               txValid,
  output logic [7:0]         txData,
  input  logic               txReady,
  output logic               irq
);

  ctlStrobe_t st;
  rdSel_t     rdSel;
  logic       rxAvail;

  sio_cmd_decode u_dec (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .rxAvail   (rxAvail),
    .st        (st),
    .rdSel     (rdSel)
  );

  sio_regfile #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .BAUD_DIV   (BAUD_DIV)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .rdSel      (rdSel),
    .wrData     (busWrData),
    .rdData     (busRdData),
    .rxLevel    (rxLevel),
    .rxHeadData (rxHeadData),
    .rxErrBits  (rxErrBits),
    .breakEvt   (breakEvt),
    .rxAvail    (rxAvail),
    .rxFlush    (rxFlush),
    .rxEnable   (rxEnable),
    .txValid    (txValid),
    .txData     (txData),
    .txReady    (txReady),
    .irq        (irq)
  );

  assign rxPop = st.popRx;

endmodule

// File: tb/sim_sio_ctrl_regs.sv
module sim_sio_ctrl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int LW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [5:0]    busAddr = '0;
  logic          busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]    busWrData = '0;
  logic [7:0]    busRdData;
  logic [LW-1:0] rxLevel = '0;
  logic [7:0]    rxHeadData = '0;
  logic [3:0]    rxErrBits = '0;
  logic          breakEvt = 1'b0;
  logic          rxPop, rxFlush, rxEnable, txValid, txReady = 1'b0, irq;
  logic [7:0]    txData;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_ctrl_regs #(.FIFO_DEPTH(DEPTH), .BAUD_DIV(16'h1234)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .rxLevel(rxLevel), .rxHeadData(rxHeadData), .rxErrBits(rxErrBits),
    .breakEvt(breakEvt), .rxPop(rxPop), .rxFlush(rxFlush),
    .rxEnable(rxEnable), .txValid(txValid), .txData(txData),
    .txReady(txReady), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // command write that also captures rxFlush in the write cycle
  task automatic cmd(input logic [7:0] d, output logic flushSeen);
    @(negedge clk);
    busAddr = 6'h08; busWrData = d; busWrEn = 1'b1;
    #1 flushSeen = rxFlush;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d, output logic popSeen);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData; popSeen = rxPop;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic pulseBreak();
    @(negedge clk);
    breakEvt = 1'b1;
    @(negedge clk);
    breakEvt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       p, f;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(6'h04, v, p); chk("R1 status", v, 8'h08);
    rd(6'h14, v, p); chk("R1 isr", v, 0);
    rd(6'h00, v, p); chk("R1 mode1", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 txValid", txValid, 0);
    chk("R1 rxEnable", rxEnable, 0);

    // R2: mode pointer
    wr(6'h00, 8'h11);
    rd(6'h00, v, p); chk("R2 mode2 after first write", v, 8'h00);
    rd(6'h00, v, p); chk("R2 read keeps ptr", v, 8'h00);
    wr(6'h00, 8'h22);
    rd(6'h00, v, p); chk("R2 mode2 written", v, 8'h22);
    wr(6'h00, 8'h33);
    rd(6'h00, v, p); chk("R2 stays on mode2", v, 8'h33);
    cmd(8'h10, f);
    rd(6'h00, v, p); chk("R2 ptr reset to mode1", v, 8'h11);

    // R4 R5 R11: full command sweep from two start states
    for (int init = 0; init < 2; init++) begin
      for (int c = 0; c < 256; c++) begin
        int act, txf, rxf;
        logic exTx, exRx, exPtr, exBrk, exPend, exFl;
        cmd(8'h10 | (init != 0 ? 8'h05 : 8'h0A), f);
        wr(6'h00, 8'h05);
        wr(6'h00, 8'hA3);
        pulseBreak();
        wr(6'h0C, 8'h77);
        cmd(8'(c), f);
        act = (c >> 4) & 7; txf = (c >> 2) & 3; rxf = c & 3;
        exTx   = (txf == 1) ? 1'b1 : (txf == 2) ? 1'b0 : (act == 3) ? 1'b0 : (init != 0);
        exRx   = (rxf == 1) ? 1'b1 : (rxf == 2) ? 1'b0 : (act == 2) ? 1'b0 : (init != 0);
        exPtr  = (act != 1);
        exBrk  = (act != 5);
        exPend = (act != 3);
        exFl   = (act == 2);
        chk("R4 rxFlush pulse", f, exFl);
        chk("R4 rxEnable", rxEnable, exRx);
        chk("R6 txValid", txValid, exTx && exPend);
        rd(6'h04, v, p); chk("R5 status", v, {4'b0, ~exPend, exTx, 2'b00});
        rd(6'h00, v, p); chk("R11 mode ptr", v, exPtr ? 8'hA3 : 8'h05);
        rd(6'h14, v, p); chk("R8 isr after cmd", v, {5'b0, exBrk, 1'b0, exTx});
      end
    end

    // R3: status layout over all levels and error patterns
    cmd(8'h38, f);
    for (int e = 0; e < 16; e++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        @(negedge clk);
        rxErrBits = 4'(e); rxLevel = LW'(l);
        rd(6'h04, v, p);
        chk("R3 status", v, {4'(e), 1'b1, 1'b0, (l == DEPTH), (l != 0)});
      end
    end
    rxErrBits = '0;

    // R8 R9: interrupt status and irq sweep
    for (int m6 = 0; m6 < 2; m6++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        for (int te = 0; te < 2; te++) begin
          for (int mk = 0; mk < 3; mk++) begin
            logic [7:0] exIsr;
            cmd(8'h50, f);
            cmd(8'h10 | (te != 0 ? 8'h04 : 8'h08), f);
            wr(6'h00, 8'(m6 << 6));
            rxLevel = LW'(l);
            exIsr = {5'b0, 1'b0, (m6 != 0) ? (l == DEPTH) : (l != 0), te != 0};
            rd(6'h14, v, p); chk("R8 isr", v, exIsr);
            wr(6'h14, 8'(1 << mk));
            @(negedge clk);
            chk("R9 irq", irq, |(exIsr & 8'(1 << mk)));
          end
        end
      end
    end
    pulseBreak();
    wr(6'h14, 8'h04);
    @(negedge clk);
    chk("R9 irq on break latch", irq, 1);
    wr(6'h14, 8'h00);
    @(negedge clk);
    chk("R9 irq masked", irq, 0);
    rxLevel = '0;

    // R6: transmit hand-off
    cmd(8'h38, f);
    wr(6'h0C, 8'h5A);
    chk("R6 held while disabled", txValid, 0);
    rd(6'h04, v, p); chk("R6 pending not empty", v[3], 0);
    cmd(8'h04, f);
    chk("R6 valid after enable", txValid, 1);
    chk("R6 data", txData, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R6 stall keeps valid", txValid, 1);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    chk("R6 accepted", txValid, 0);
    rd(6'h04, v, p); chk("R6 empty after accept", v[3], 1);
    chk("R6 tx ready flag", v[2], 1);

    // R7: receive read
    rxLevel = LW'(2); rxHeadData = 8'h3C;
    rd(6'h0C, v, p); chk("R7 rx data", v, 8'h3C); chk("R7 pop", p, 1);
    rxLevel = '0;
    rd(6'h0C, v, p); chk("R7 empty data", v, 0); chk("R7 no pop", p, 0);

    // R10: address sweep reads
    cmd(8'h50, f);
    cmd(8'h3A, f);
    wr(6'h00, 8'h00);
    wr(6'h14, 8'h00);
    for (int a = 0; a < 64; a++) begin
      logic [7:0] exv;
      case (a)
        'h04: exv = 8'h08;
        'h18: exv = 8'h12;
        'h1C: exv = 8'h34;
        default: exv = 8'h00;
      endcase
      rd(6'(a), v, p);
      chk("R10 read map", v, exv);
    end
    // R10: writes to other addresses change nothing
    for (int a = 0; a < 64; a++) begin
      if (a != 'h00 && a != 'h08 && a != 'h0C && a != 'h14) wr(6'(a), 8'hFF);
    end
    rd(6'h00, v, p); chk("R10 mode untouched", v, 0);
    rd(6'h04, v, p); chk("R10 status untouched", v, 8'h08);
    rd(6'h14, v, p); chk("R10 isr untouched", v, 0);
    chk("R10 irq untouched", irq, 0);
    chk("R10 rx untouched", rxEnable, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule